// File: doc/BRIEF.md
# Lock-Bit Clear Command Sequencer

This block is the command front end that a flash-like device uses to release every block lock bit in one operation. The host issues byte-wide bus writes. A setup byte arms the sequencer, and the following write must carry the confirm byte. When the voltages are good, a timed internal erase of the lock bits starts. While it runs, the ready/busy pin is low and status bit 7 reads 0. When it ends, all lock bits are 0.

Every failure leaves a sticky pair of status bits set until the host writes the clear-status command:

- a bad second write,
- a programming voltage below lockout at confirm time,
- an abort or voltage loss during the timed phase.

An aborted operation marks every block's lock state as unknown. Only a later complete clear makes the state known again. The read path switches to status mode as soon as the setup byte is accepted, and it stays there until the read-array command is written.

Command bytes: setup `8'h60`, confirm `8'hD0`, clear-status `8'h50`, read-array `8'hFF`.

Top module: `lock_clear_seq`

## Requirements
- R1: After reset, `status` reads `8'h80`, `ready_pin` is 1, `rd_status_mode` is 0, `lock_bits` equals `LOCK_INIT` and `lock_unknown` is all 0. Status bits 6, 2, 1 and 0 always read 0.
- R2: A setup write (`8'h60`) followed by a confirm write (`8'hD0`), with `vpen_ok` and `vcc_ok` high and no abort, holds `status[7]` and `ready_pin` at 0 for exactly `BUSY_CYCLES` cycles starting at the confirm edge. After that, both are 1, `lock_bits` is all 0 and `status` reads `8'h80`.
- R3: Accepting the setup byte puts the read path into status mode (`rd_status_mode`=1). It stays there through confirm, the busy phase and completion, and it leaves only when `8'hFF` is written outside the busy phase.
- R4: After a setup write, any second write other than `8'hD0` sets `status[5]` and `status[4]` to 1. It starts no busy phase and leaves `lock_bits` unchanged.
- R5: A confirm write while `vpen_ok` is 0 sets `status[5]` and `status[3]` to 1. It starts no busy phase and leaves `lock_bits` unchanged.
- R6: During the busy phase, `abort` high, `vcc_ok` low or `vpen_ok` low ends the operation on the next edge. The effects are:
  - `ready_pin` returns to 1;
  - `lock_unknown` becomes all 1;
  - `lock_bits` is unchanged;
  - `status[5]` is set, and `status[3]` is also set when `vpen_ok` was the cause.
- R7: A later successful clear returns `lock_unknown` to all 0.
- R8: Status error bits 5, 4 and 3 keep their value across other commands. A `8'h50` write outside the busy phase clears them on that edge and leaves `rd_status_mode` unchanged.
- R9: A setup write while `suspend_in` is 1 is ignored. The read mode is unchanged, and a following `8'hD0` starts nothing.
- R10: Writes during the busy phase are ignored. In particular, `8'hFF` does not leave status mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_data | input | 8 | Command byte |
| vpen_ok | input | 1 | Programming voltage above lockout |
| vcc_ok | input | 1 | Supply in valid range |
| abort | input | 1 | Abort request for the running operation |
| suspend_in | input | 1 | Device is suspended; setup refused |
| rd_status_mode | output | 1 | Read path returns status (1) or array (0) |
| status | output | 8 | Status register |
| ready_pin | output | 1 | Ready (1) / busy (0) pin |
| lock_bits | output | NUM_BLOCKS | Block lock bits |
| lock_unknown | output | NUM_BLOCKS | Per-block indeterminate-lock flags |

## Verification
Every command effect is registered once. A write presented before an edge is visible at all outputs in the half cycle after that edge, so the bench drives on the falling edge and samples on the next falling edge. The busy pin drops in the same sample as the confirm write. It is then counted low over `BUSY_CYCLES`-1 further samples and must be high one sample later. An abort raised after the confirm edge must show as ready with every unknown flag set one sample later. The second-write check sweeps all 255 non-confirm codes, with a clear-status between trials.

// File: rtl/lkclr_pkg.sv
package lkclr_pkg;

    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    typedef enum logic [1:0] {
        ST_ARRAY    = 2'd0,
        ST_STATREAD = 2'd1,
        ST_SETUP    = 2'd2,
        ST_BUSY     = 2'd3
    } seq_state_t;

    // declared MSB first: maps onto status bits 5,4,3
    typedef struct packed {
        logic op_err;
        logic seq_err;
        logic vpp_low;
    } err_flags_t;

    function automatic logic [7:0] pack_status(input logic rdy, input err_flags_t f);
        return {rdy, 1'b0, f.op_err, f.seq_err, f.vpp_low, 3'b000};
    endfunction

endpackage

// File: rtl/lkclr_timer.sv
module lkclr_timer #(
    parameter int CYCLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (cancel) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run_q && (cnt_q == '0);

    // R2
    no_start_while_running_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !run_q);
endmodule

// File: rtl/lkclr_errflags.sv
module lkclr_errflags
    import lkclr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_flags_t set_in,
    input  logic       clr,
    output err_flags_t flags
);
    err_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst)      flags_q <= '0;
        else if (clr) flags_q <= set_in;
        else          flags_q <= flags_q | set_in;
    end

    assign flags = flags_q;

    // R8
    flags_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && set_in == '0) |=> (flags == '0));
    // R8
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/lock_clear_seq.sv
module lock_clear_seq
    import lkclr_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BUSY_CYCLES = 6,
    parameter logic [NUM_BLOCKS-1:0] LOCK_INIT = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    input  logic                  vpen_ok,
    input  logic                  vcc_ok,
    input  logic                  abort,
    input  logic                  suspend_in,
    output logic                  rd_status_mode,
    output logic [7:0]            status,
    output logic                  ready_pin,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic [NUM_BLOCKS-1:0] lock_unknown
);
    seq_state_t state, nxt;
    logic       tmr_start, tmr_cancel, tmr_done;
    logic       err_clr, clr_done, op_abort;
    err_flags_t err_set, flags;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ARRAY;
        else     state <= nxt;
    end

    always_comb begin
        nxt        = state;
        tmr_start  = 1'b0;
        tmr_cancel = 1'b0;
        err_set    = '0;
        err_clr    = 1'b0;
        clr_done   = 1'b0;
        op_abort   = 1'b0;
        unique case (state)
            ST_ARRAY, ST_STATREAD: begin
                if (wr_en) begin
                    if (wr_data == CMD_SETUP) begin
                        if (!suspend_in) nxt = ST_SETUP;
                    end else if (wr_data == CMD_CLRSTAT) begin
                        err_clr = 1'b1;
                    end else if (wr_data == CMD_ARRAY) begin
                        nxt = ST_ARRAY;
                    end
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    nxt = ST_STATREAD;
                    if (wr_data != CMD_CONFIRM) begin
                        err_set.op_err  = 1'b1;
                        err_set.seq_err = 1'b1;
                    end else if (!vpen_ok) begin
                        err_set.op_err  = 1'b1;
                        err_set.vpp_low = 1'b1;
                    end else begin
                        tmr_start = 1'b1;
                        nxt       = ST_BUSY;
                    end
                end
            end
            ST_BUSY: begin
                if (abort || !vpen_ok || !vcc_ok) begin
                    op_abort        = 1'b1;
                    tmr_cancel      = 1'b1;
                    err_set.op_err  = 1'b1;
                    err_set.vpp_low = !vpen_ok;
                    nxt             = ST_STATREAD;
                end else if (tmr_done) begin
                    clr_done = 1'b1;
                    nxt      = ST_STATREAD;
                end
            end
            default: nxt = ST_ARRAY;
        endcase
    end

    lkclr_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .cancel (tmr_cancel),
        .done   (tmr_done)
    );

    lkclr_errflags u_err (
        .clk    (clk),
        .rst    (rst),
        .set_in (err_set),
        .clr    (err_clr),
        .flags  (flags)
    );

    logic [NUM_BLOCKS-1:0] lock_q, unk_q;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[b] <= LOCK_INIT[b];
                unk_q[b]  <= 1'b0;
            end else if (clr_done) begin
                lock_q[b] <= 1'b0;
                unk_q[b]  <= 1'b0;
            end else if (op_abort) begin
                unk_q[b]  <= 1'b1;
            end
        end
    end

    assign ready_pin      = (state != ST_BUSY);
    assign rd_status_mode = (state != ST_ARRAY);
    assign status         = pack_status(ready_pin, flags);
    assign lock_bits      = lock_q;
    assign lock_unknown   = unk_q;

    // R2
    lock_change_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_q) |-> (lock_q == '0 && $past(tmr_done)));
    // R4
    bad_second_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && wr_en && wr_data != CMD_CONFIRM) |=> (status[5:4] == 2'b11 && ready_pin));
    // R5
    low_vpen_confirm_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && wr_en && wr_data == CMD_CONFIRM && !vpen_ok) |=> (status[5] && status[3] && ready_pin));
    // R6
    abort_unknown_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && abort) |=> (ready_pin && (&unk_q) && status[5]));
    // R3
    status_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ARRAY && !(wr_en && wr_data == CMD_ARRAY)) |=> rd_status_mode);
    // R9
    suspend_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARRAY && wr_en && suspend_in) |=> !rd_status_mode);
endmodule

// File: tb/lock_clear_seq_test.sv
module lock_clear_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int BC = 6;
    localparam logic [NB-1:0] INIT = {NB{1'b1}};

    logic clk = 1'b0;
    logic rst, wr_en, vpen_ok, vcc_ok, abort, suspend_in;
    logic [7:0] wr_data;
    logic rd_status_mode, ready_pin;
    logic [7:0] status;
    logic [NB-1:0] lock_bits, lock_unknown;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_clear_seq #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BC), .LOCK_INIT(INIT)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .vpen_ok(vpen_ok), .vcc_ok(vcc_ok), .abort(abort), .suspend_in(suspend_in),
        .rd_status_mode(rd_status_mode), .status(status), .ready_pin(ready_pin),
        .lock_bits(lock_bits), .lock_unknown(lock_unknown)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        vpen_ok = 1'b1; vcc_ok = 1'b1; abort = 1'b0; suspend_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 status", status, 8'h80);
        chk("R1 ready", ready_pin, 1);
        chk("R1 mode", rd_status_mode, 0);
        chk("R1 locks", lock_bits, INIT);
        chk("R1 unknown", lock_unknown, 0);

        // R9 suspended setup ignored
        suspend_in = 1'b1;
        wr(8'h60);
        chk("R9 mode", rd_status_mode, 0);
        suspend_in = 1'b0;
        wr(8'hD0);
        chk("R9 ready", ready_pin, 1);
        chk("R9 locks", lock_bits, INIT);

        // R4 sweep of every non-confirm second write, R8 clear between
        for (int v = 0; v < 256; v++) begin
            if (v != 8'hD0) begin
                wr(8'h60);
                chk("R3 setup mode", rd_status_mode, 1);
                wr(v[7:0]);
                chk("R4 status", status, 8'hB0);
                chk("R4 locks", lock_bits, INIT);
                wr(8'h50);
                chk("R8 cleared", status, 8'h80);
                chk("R8 mode kept", rd_status_mode, 1);
            end
        end
        wr(8'hFF);
        chk("R3 array", rd_status_mode, 0);

        // R5 low programming voltage at confirm
        wr(8'h60);
        vpen_ok = 1'b0;
        wr(8'hD0);
        vpen_ok = 1'b1;
        chk("R5 status", status, 8'hA8);
        chk("R5 locks", lock_bits, INIT);
        // R8 sticky across other commands
        wr(8'hFF);
        wr(8'h00);
        chk("R8 sticky", status, 8'hA8);
        chk("R8 array mode", rd_status_mode, 0);
        wr(8'h50);
        chk("R8 clear", status, 8'h88 & 8'h80);

        // R6 abort during busy
        wr(8'h60);
        wr(8'hD0);
        chk("R2 busy start", ready_pin, 0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R6 ready", ready_pin, 1);
        chk("R6 unknown", lock_unknown, {NB{1'b1}});
        chk("R6 locks", lock_bits, INIT);
        chk("R6 status", status, 8'hA0);
        wr(8'h50);

        // R6 programming-voltage loss during busy
        wr(8'h60);
        wr(8'hD0);
        @(negedge clk);
        vpen_ok = 1'b0;
        @(negedge clk);
        vpen_ok = 1'b1;
        chk("R6 vpen status", status, 8'hA8);
        wr(8'h50);

        // R6 supply loss during busy
        wr(8'h60);
        wr(8'hD0);
        vcc_ok = 1'b0;
        @(negedge clk);
        vcc_ok = 1'b1;
        chk("R6 vcc status", status, 8'hA0);
        chk("R6 vcc locks", lock_bits, INIT);
        wr(8'h50);
        wr(8'hFF);

        // R2 full clear, R10 writes ignored while busy, R7 unknown reset
        wr(8'h60);
        wr(8'hD0);
        chk("R2 busy 0", {ready_pin, status[7]}, 0);
        for (int k = 1; k < BC; k++) begin
            if (k == 1) wr(8'hFF);
            else if (k == 2) wr(8'h60);
            else @(negedge clk);
            chk("R2 busy", {ready_pin, status[7]}, 0);
            chk("R10 mode", rd_status_mode, 1);
        end
        @(negedge clk);
        chk("R2 ready", ready_pin, 1);
        chk("R2 status", status, 8'h80);
        chk("R2 locks", lock_bits, 0);
        chk("R7 unknown", lock_unknown, 0);
        chk("R3 after done", rd_status_mode, 1);
        wr(8'hFF);
        chk("R3 exit", rd_status_mode, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule